// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two predictors side by side and letting a third table decide which one to trust. The local side keeps a separate history shift register for each branch, selected by PC bits. That history value addresses a table of 2-bit saturating counters. The global side keeps one shift register that records the outcomes of all resolved branches. That register addresses its own counter table. A chooser table, also selected by PC bits, holds 2-bit counters whose upper bit picks the component whose prediction becomes the final answer.

Lookup is combinational from the fetch PC. The fetch stage keeps both component predictions alongside the branch. When the branch resolves, the pipeline returns those predictions together with the branch PC and the real outcome on the update port. Both components train on every resolved branch. The chooser moves only when exactly one component was correct.

Top module: `tournament_pred`

## Requirements
- R1: After reset, every local history and the global history are zero. Every component counter is weakly not-taken (01), so both component predictions are 0. Every chooser counter is weakly-global (10), so `pred_use_global_o`=1 and `pred_taken_o`=0.
- R2: A valid update shifts the outcome into the LSB of the local history entry selected by `upd_pc_i[PC_LSB +: LIDX_W]`. The older bits move one place toward the MSB. No other local history entry changes.
- R3: The local prediction is the MSB of the local counter addressed by the fetch PC's local history. A valid update steps the counter addressed by the update PC's current local history. It moves up on taken and down on not-taken, and saturates at 00 and 11.
- R4: The global prediction is the MSB of the global counter addressed by the global history. A valid update steps that counter by the same saturating rule and then shifts the outcome into the history LSB.
- R5: `pred_taken_o` equals the global prediction when `pred_use_global_o`=1 and the local prediction when it is 0. `pred_use_global_o` is the MSB of the chooser counter at `fetch_pc_i[PC_LSB +: CIDX_W]`.
- R6: On a valid update, the chooser counter at the update PC moves up (toward global) when only the returned global prediction matched the outcome. It moves down when only the returned local prediction matched. It holds when both matched or neither did. It saturates at 00 and 11.
- R7: Both component tables and both histories train on every valid update, regardless of which component the chooser selected.
- R8: With `LHIST_W` of 6 or more, a single branch repeating taken, taken, not-taken gets a correct local prediction on every instance once trained.
- R9: When `upd_valid_i`=0, no state changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | PC_W | PC being looked up |
| pred_taken_o | output | 1 | Final direction prediction |
| pred_use_global_o | output | 1 | 1 = global component chosen |
| pred_local_o | output | 1 | Local component prediction |
| pred_global_o | output | 1 | Global component prediction |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_local_pred_i | input | 1 | Local prediction captured at lookup |
| upd_global_pred_i | input | 1 | Global prediction captured at lookup |

## Verification
The bench builds the block with 8-bit PCs, a 4-entry local history table of 6-bit histories, a 4-bit global history and a 4-entry chooser. This keeps every table small enough that a stream of a few thousand branches over 16 word addresses drives each counter and chooser entry through saturation, aliasing and all chooser transitions. The 6-bit local history makes the three-outcome loop case reachable. The short global history wraps often, so each global counter is revisited many times. Idle cycles carry random update fields to exercise the hold behaviour.

// File: rtl/tour_pkg.sv
package tour_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_next(ctr_t c, logic up);
    if (up) return (c == CTR_ST)  ? c : ctr_t'(c + 2'd1);
    else    return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
  endfunction
endpackage

// File: rtl/tour_ctr_table.sv
module tour_ctr_table import tour_pkg::*; #(
  parameter int   IDX_W = 4,
  parameter ctr_t INIT  = CTR_WNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_next(mem_q[wr_idx_i], up_i);
    end
  end

  assign rd_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tour_hist_table.sv
module tour_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] wr_hist_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= HIST_W'({hist_q[wr_idx_i], bit_i});
    end
  end

  assign rd_hist_o = hist_q[rd_idx_i];
  assign wr_hist_o = hist_q[wr_idx_i];
endmodule

// File: rtl/tour_ghr.sv
module tour_ghr #(
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= HIST_W'({hist_q, bit_i});
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tournament_pred.sv
module tournament_pred import tour_pkg::*; #(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int LIDX_W  = 6,
  parameter int LHIST_W = 8,
  parameter int GHIST_W = 10,
  parameter int CIDX_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic            pred_use_global_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_pred_i,
  input  logic            upd_global_pred_i
);
  logic [LIDX_W-1:0]  lidx_f, lidx_u;
  logic [CIDX_W-1:0]  cidx_f, cidx_u;
  logic [LHIST_W-1:0] lhist_f, lhist_u;
  logic [GHIST_W-1:0] ghr_q;
  ctr_t               lctr_f, gctr_f, cctr_f;
  logic               local_ok, global_ok, cho_we;

  assign lidx_f = fetch_pc_i[PC_LSB +: LIDX_W];
  assign lidx_u = upd_pc_i[PC_LSB +: LIDX_W];
  assign cidx_f = fetch_pc_i[PC_LSB +: CIDX_W];
  assign cidx_u = upd_pc_i[PC_LSB +: CIDX_W];

  // per-branch history, first level of the local side
  tour_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) i_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (lidx_f),
    .rd_hist_o(lhist_f),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (lidx_u),
    .bit_i    (upd_taken_i),
    .wr_hist_o(lhist_u)
  );

  // counter update uses the history before this outcome is shifted in
  tour_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WNT)) i_lpt (
    .clk_i, .rst_ni,
    .rd_idx_i(lhist_f),
    .rd_o    (lctr_f),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(lhist_u),
    .up_i    (upd_taken_i)
  );

  tour_ghr #(.HIST_W(GHIST_W)) i_ghr (
    .clk_i, .rst_ni,
    .en_i  (upd_valid_i),
    .bit_i (upd_taken_i),
    .hist_o(ghr_q)
  );

  tour_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WNT)) i_gpt (
    .clk_i, .rst_ni,
    .rd_idx_i(ghr_q),
    .rd_o    (gctr_f),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(ghr_q),
    .up_i    (upd_taken_i)
  );

  assign local_ok  = (upd_local_pred_i  == upd_taken_i);
  assign global_ok = (upd_global_pred_i == upd_taken_i);
  assign cho_we    = upd_valid_i && (local_ok != global_ok);

  tour_ctr_table #(.IDX_W(CIDX_W), .INIT(CTR_WT)) i_cht (
    .clk_i, .rst_ni,
    .rd_idx_i(cidx_f),
    .rd_o    (cctr_f),
    .wr_en_i (cho_we),
    .wr_idx_i(cidx_u),
    .up_i    (global_ok)
  );

  assign pred_local_o      = lctr_f[1];
  assign pred_global_o     = gctr_f[1];
  assign pred_use_global_o = cctr_f[1];
  assign pred_taken_o      = pred_use_global_o ? pred_global_o : pred_local_o;
endmodule

// File: rtl/tournament_pred_chk.sv
module tournament_pred_chk #(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int LIDX_W  = 6,
  parameter int LHIST_W = 8,
  parameter int GHIST_W = 10,
  parameter int CIDX_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PC_W-1:0]    fetch_pc_i,
  input logic               pred_taken_o,
  input logic               pred_use_global_o,
  input logic               pred_local_o,
  input logic               pred_global_o,
  input logic               upd_valid_i,
  input logic [PC_W-1:0]    upd_pc_i,
  input logic               upd_taken_i,
  input logic               upd_local_pred_i,
  input logic               upd_global_pred_i,
  input logic [GHIST_W-1:0] ghr_q,
  input logic [LHIST_W-1:0] lhist_u
);
  logic same_cidx;
  assign same_cidx = fetch_pc_i[PC_LSB +: CIDX_W] == upd_pc_i[PC_LSB +: CIDX_W];

  AST_GHR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghr_q == GHIST_W'({$past(ghr_q), $past(upd_taken_i)})); // R4

  AST_GHR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q)); // R9

  AST_LHIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i ##1 $stable(upd_pc_i)) |->
      lhist_u == LHIST_W'({$past(lhist_u), $past(upd_taken_i)})); // R2

  AST_AGREE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_local_o == pred_global_o) |-> (pred_taken_o == pred_local_o)); // R5

  AST_CHOOSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && (upd_local_pred_i == upd_global_pred_i) && same_cidx
     ##1 $stable(fetch_pc_i)) |-> $stable(pred_use_global_o)); // R6

  AST_IDLE_CHOOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i ##1 $stable(fetch_pc_i)) |-> $stable(pred_use_global_o)); // R9
endmodule

bind tournament_pred tournament_pred_chk #(
  .PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W),
  .LHIST_W(LHIST_W), .GHIST_W(GHIST_W), .CIDX_W(CIDX_W)
) i_chk (.*);

// File: tb/test_tournament_pred.sv
module test_tournament_pred;
  localparam int PC_W = 8, PC_LSB = 2, LIDX_W = 2, LHIST_W = 6, GHIST_W = 4, CIDX_W = 2;
  localparam int LE = 1 << LIDX_W, CE = 1 << CIDX_W;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni;
  logic [PC_W-1:0] fetch_pc_i, upd_pc_i;
  logic pred_taken_o, pred_use_global_o, pred_local_o, pred_global_o;
  logic upd_valid_i, upd_taken_i, upd_local_pred_i, upd_global_pred_i;

  tournament_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W),
                    .GHIST_W(GHIST_W), .CIDX_W(CIDX_W)) i_tournament_pred (.*);

  int checks = 0, fails = 0;
  int lht [LE];
  int lpt [1 << LHIST_W];
  int gpt [1 << GHIST_W];
  int cht [CE];
  int ghr;
  logic [15:0] lfsr = 16'hace1;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (lht[i]) lht[i] = 0;
    foreach (lpt[i]) lpt[i] = 1;
    foreach (gpt[i]) gpt[i] = 1;
    foreach (cht[i]) cht[i] = 2;
    ghr = 0;
  endtask

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_update(int pc, bit t, bit lp, bit gp);
    int li = (pc >> PC_LSB) % LE;
    int ci = (pc >> PC_LSB) % CE;
    lpt[lht[li]] = sat(lpt[lht[li]], t);
    lht[li] = ((lht[li] << 1) | int'(t)) % (1 << LHIST_W);
    gpt[ghr] = sat(gpt[ghr], t);
    ghr = ((ghr << 1) | int'(t)) % (1 << GHIST_W);
    if ((gp == t) && (lp != t)) cht[ci] = sat(cht[ci], 1'b1);
    if ((lp == t) && (gp != t)) cht[ci] = sat(cht[ci], 1'b0);
  endtask

  // one lookup, compare against model, then present the update
  task automatic branch(int pc, bit t, bit valid, output bit local_ok);
    bit elp, egp, eug, efin, lp, gp;
    @(negedge clk_i);
    fetch_pc_i = PC_W'(pc);
    #1;
    elp  = lpt[lht[(pc >> PC_LSB) % LE]] >= 2;
    egp  = gpt[ghr] >= 2;
    eug  = cht[(pc >> PC_LSB) % CE] >= 2;
    efin = eug ? egp : elp;
    chk(pred_local_o == elp, "R2 R3 R7 local prediction", pred_local_o, elp);
    chk(pred_global_o == egp, "R4 R7 global prediction", pred_global_o, egp);
    chk(pred_use_global_o == eug, "R6 chooser select", pred_use_global_o, eug);
    chk(pred_taken_o == efin, "R5 final prediction", pred_taken_o, efin);
    lp = pred_local_o;
    gp = pred_global_o;
    local_ok = (lp == t);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    upd_valid_i = valid;
    upd_pc_i    = valid ? PC_W'(pc) : lfsr[7:0];
    upd_taken_i = valid ? t : lfsr[8];
    upd_local_pred_i  = valid ? lp : lfsr[9];
    upd_global_pred_i = valid ? gp : lfsr[10];
    @(posedge clk_i);
    #1;
    if (valid) model_update(pc, t, lp, gp);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    upd_valid_i = 1'b0;
    model_reset();
    #2;
    for (int p = 0; p < 16; p++) begin
      fetch_pc_i = PC_W'(p << PC_LSB);
      #1;
      chk(pred_taken_o == 1'b0, "R1 reset final", pred_taken_o, 0);
      chk(pred_use_global_o == 1'b1, "R1 reset chooser", pred_use_global_o, 1);
      chk(pred_local_o == 1'b0 && pred_global_o == 1'b0, "R1 reset components",
          {pred_local_o, pred_global_o}, 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    bit ok;
    int pc;
    bit t;
    fetch_pc_i = '0; upd_pc_i = '0; upd_taken_i = 0;
    upd_local_pred_i = 0; upd_global_pred_i = 0; upd_valid_i = 0;
    rst_ni = 1'b1;
    do_reset();

    // phase A: per-address bias, outcome tied to PC bits; idle every 7th cycle
    for (int n = 0; n < 1500; n++) begin
      pc = int'(lfsr[3:0]) << PC_LSB;
      t  = (lfsr[3:0] % 3 != 0) ^ (n % 11 == 0);
      branch(pc, t, (n % 7) != 3, ok);
    end
    // phase B: fully random outcomes push choosers both ways
    for (int n = 0; n < 1500; n++) begin
      pc = int'(lfsr[5:2]) << PC_LSB;
      t  = lfsr[11];
      branch(pc, t, (n % 5) != 0, ok);
    end

    // R8: T,T,N loop on one branch, local side must be exact once trained
    do_reset();
    for (int r = 0; r < 30; r++) begin
      for (int k = 0; k < 3; k++) begin
        t = (k != 2);
        branch(8'h24, t, 1'b1, ok);
        if (r >= 10) chk(ok, "R8 loop local prediction", !ok, 0);
      end
    end

    @(negedge clk_i);
    upd_valid_i = 1'b0;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule